// File: doc/BRIEF.md
# Standby Power-Mode Sequencer

This block steps a small processor subsystem into and out of a low-power standby state. An idle request pulse starts the entry. The system clock keeps running for a flush interval so that pending work can drain. The block then turns off the system and peripheral clock enables. The PLL and watchdog clock enables stay on the whole time.

In standby the block watches an external wake input. The input passes through a two-flop synchronizer and must then stay high for a qualification width before it counts as a wake. The qualification width is either fixed or programmable. Once a wake is accepted, the block waits a resume latency. That latency is longer when the flash is asleep. After the latency it turns the clocks back on, pulses a resume strobe and, if enabled, forwards a wake interrupt.

Top module: `standby_seq`

## Requirements
- R1: After an idle request accepted in the normal state, the status reads flushing for exactly 32 cycles when `clk_div` is 0, or exactly 64 cycles when it is 1, and then reads standby.
- R2: In the normal and flushing states `sys_clk_en` and `periph_clk_en` are 1. In the standby and waking states both are 0. `pll_clk_en` and `wdog_clk_en` are 1 in every state.
- R3: With `qual_en` = 0, a wake input held high for 3 consecutive cycles while in standby is accepted. The status reads waking two cycles after the input is released.
- R4: With `qual_en` = 1, the wake input must stay high for 2 + `qual_cnt` consecutive cycles, with `qual_cnt` a 6-bit value. Timing is otherwise as in R3.
- R5: A wake pulse one cycle shorter than the required width does not cause an exit, even when pulses are repeated with a one-cycle gap.
- R6: After a wake is accepted, the status reads waking for 100 cycles when `flash_sleep` is 0, or 1125 cycles when it is 1. It then returns to normal with `resume` high for that first normal cycle only.
- R7: `wake_irq` pulses together with `resume` only when `wake_irq_en` is 1, and is otherwise 0.
- R8: An idle request that arrives while the status is not normal is ignored: it neither restarts the flush count nor causes any state change.
- R9: The status encodes normal=0, flushing=1, standby=2 and waking=3. After synchronous reset the status is normal, `resume` is 0 and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req | input | 1 | One-cycle request to enter standby |
| wake_in | input | 1 | Asynchronous external wake input |
| qual_en | input | 1 | Selects the programmable qualification width |
| qual_cnt | input | 6 | Extra qualification cycles beyond 2 |
| clk_div | input | 1 | Selects the 64-cycle flush instead of 32 |
| flash_sleep | input | 1 | Selects the 1125-cycle resume latency |
| wake_irq_en | input | 1 | Lets the wake interrupt through on resume |
| sys_clk_en | output | 1 | System clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_clk_en | output | 1 | PLL domain enable |
| wdog_clk_en | output | 1 | Watchdog domain enable |
| status | output | 2 | Current state code |
| resume | output | 1 | One-cycle strobe when execution may resume |
| wake_irq | output | 1 | One-cycle wake interrupt request |

## Verification
The bench measures each flush and latency interval to the exact cycle, for both divider settings and both flash settings. An off-by-one counter would show up as a 31-, 65- or 1124-cycle interval. Wake pulses exactly one cycle short of the qualification width are sent, both alone and as a train with one-cycle gaps. A qualifier that failed to clear on a dropout would add up the pieces and leave standby. Idle requests are sent during flushing and during standby. A block that restarted the flush, or re-entered flushing, would show a longer flush or a wrong status. The interrupt is tried with its enable both set and clear.

// File: rtl/standby_seq.sv
module standby_seq #(
  parameter int FLUSH_SHORT = 32,
  parameter int FLUSH_LONG  = 64,
  parameter int RES_FAST    = 100,
  parameter int RES_SLOW    = 1125,
  parameter int QW          = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle_req,
  input  logic          wake_in,
  input  logic          qual_en,
  input  logic [QW-1:0] qual_cnt,
  input  logic          clk_div,
  input  logic          flash_sleep,
  input  logic          wake_irq_en,
  output logic          sys_clk_en,
  output logic          periph_clk_en,
  output logic          pll_clk_en,
  output logic          wdog_clk_en,
  output logic [1:0]    status,
  output logic          resume,
  output logic          wake_irq
);
  localparam int CMAX = (RES_SLOW > FLUSH_LONG) ? RES_SLOW : FLUSH_LONG;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int NW   = QW + 1;

  localparam logic [1:0] S_RUN = 2'd0, S_FLUSH = 2'd1, S_STBY = 2'd2, S_WAKE = 2'd3;

  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic [NW-1:0] qcnt;
  logic          s1, s2;
  logic [CW-1:0] flen, rlen;
  logic [NW-1:0] need;

  assign flen = clk_div ? CW'(FLUSH_LONG) : CW'(FLUSH_SHORT);
  assign rlen = flash_sleep ? CW'(RES_SLOW) : CW'(RES_FAST);
  assign need = qual_en ? NW'(2) + NW'(qual_cnt) : NW'(3);

  assign status        = st;
  assign sys_clk_en    = (st == S_RUN) || (st == S_FLUSH);
  assign periph_clk_en = (st == S_RUN) || (st == S_FLUSH);
  assign pll_clk_en    = 1'b1;
  assign wdog_clk_en   = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= wake_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_RUN;
      cnt      <= '0;
      qcnt     <= '0;
      resume   <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      resume   <= 1'b0;
      wake_irq <= 1'b0;
      case (st)
        S_RUN: begin
          cnt  <= '0;
          qcnt <= '0;
          if (idle_req) st <= S_FLUSH;
        end
        S_FLUSH: begin
          if (cnt == flen - CW'(1)) begin
            st  <= S_STBY;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_STBY: begin
          if (!s2) begin
            qcnt <= '0;
          end else if (qcnt == need - NW'(1)) begin
            st   <= S_WAKE;
            qcnt <= '0;
            cnt  <= '0;
          end else begin
            qcnt <= qcnt + NW'(1);
          end
        end
        default: begin
          if (cnt == rlen - CW'(1)) begin
            st       <= S_RUN;
            cnt      <= '0;
            resume   <= 1'b1;
            wake_irq <= wake_irq_en;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      endcase
    end
  end

  p_flush_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_FLUSH && cnt != flen - CW'(1)) |=> st == S_FLUSH);

  p_gated_in_standby_r2: assert property (@(posedge clk) disable iff (rst)
    (status == S_STBY) |-> (!periph_clk_en && !sys_clk_en && pll_clk_en && wdog_clk_en));

  p_no_unqualified_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_STBY && !s2) |=> st == S_STBY);

  p_resume_after_wake_r6: assert property (@(posedge clk) disable iff (rst)
    resume |-> (st == S_RUN && $past(st) == S_WAKE));

  p_irq_with_resume_r7: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> resume);

  p_idle_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_STBY && idle_req && !s2) |=> st == S_STBY);
endmodule

// File: tb/tb_standby_seq.sv
module tb_standby_seq;
  logic clk = 0, rst = 1;
  logic idle_req = 0, wake_in = 0, qual_en = 0, clk_div = 0, flash_sleep = 0, wake_irq_en = 0;
  logic [5:0] qual_cnt = 0;
  logic sys_clk_en, periph_clk_en, pll_clk_en, wdog_clk_en, resume, wake_irq;
  logic [1:0] status;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  standby_seq dut (
    .clk(clk), .rst(rst), .idle_req(idle_req), .wake_in(wake_in), .qual_en(qual_en),
    .qual_cnt(qual_cnt), .clk_div(clk_div), .flash_sleep(flash_sleep),
    .wake_irq_en(wake_irq_en), .sys_clk_en(sys_clk_en), .periph_clk_en(periph_clk_en),
    .pll_clk_en(pll_clk_en), .wdog_clk_en(wdog_clk_en), .status(status),
    .resume(resume), .wake_irq(wake_irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_state(input logic [1:0] s, output int n);
    n = 0;
    while (status == s && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset status", status, 0);
    check("R9 reset resume", resume, 0);
    check("R2 run sys clk", sys_clk_en, 1);
    check("R2 run periph clk", periph_clk_en, 1);
  endtask

  task automatic pulse_wake(input int w);
    wake_in = 1;
    repeat (w) @(negedge clk);
    wake_in = 0;
  endtask

  task automatic t_cycle(input logic div, input logic qe, input int q, input logic fs, input logic ie);
    int n, need, flen, rlen;
    clk_div = div; qual_en = qe; qual_cnt = 6'(q); flash_sleep = fs; wake_irq_en = ie;
    need = qe ? 2 + q : 3;
    flen = div ? 64 : 32;
    rlen = fs ? 1125 : 100;
    idle_req = 1;
    @(negedge clk);
    idle_req = 0;
    check("R9 flushing code", status, 1);
    check("R2 flush sys clk", sys_clk_en, 1);
    count_state(2'd1, n);
    check("R1 flush length", n, flen);
    check("R9 standby code", status, 2);
    check("R2 standby periph off", periph_clk_en, 0);
    check("R2 standby sys off", sys_clk_en, 0);
    check("R2 standby pll on", pll_clk_en, 1);
    check("R2 standby wdog on", wdog_clk_en, 1);
    pulse_wake(need - 1);
    repeat (6) @(negedge clk);
    check("R5 short pulse no exit", status, 2);
    pulse_wake(need);
    repeat (2) @(negedge clk);
    check(qe ? "R4 qualified wake" : "R3 fixed wake", status, 3);
    check("R2 waking clocks off", sys_clk_en, 0);
    count_state(2'd3, n);
    check("R6 resume latency", n, rlen);
    check("R6 back to normal", status, 0);
    check("R6 resume high", resume, 1);
    check("R7 irq gated", wake_irq, ie ? 1 : 0);
    check("R2 clocks back on", periph_clk_en, 1);
    @(negedge clk);
    check("R6 resume one cycle", resume, 0);
    check("R7 irq one cycle", wake_irq, 0);
  endtask

  task automatic t_dropout;
    int n;
    clk_div = 0; qual_en = 1; qual_cnt = 6'd4; flash_sleep = 0; wake_irq_en = 0;
    idle_req = 1;
    @(negedge clk);
    idle_req = 0;
    repeat (10) @(negedge clk);
    idle_req = 1;
    @(negedge clk);
    idle_req = 0;
    check("R8 idle during flush keeps state", status, 1);
    count_state(2'd1, n);
    check("R8 flush not restarted", n, 32 - 11);
    idle_req = 1;
    @(negedge clk);
    idle_req = 0;
    @(negedge clk);
    check("R8 idle in standby ignored", status, 2);
    for (int i = 0; i < 4; i++) begin
      pulse_wake(5);
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check("R5 dropout train no exit", status, 2);
    pulse_wake(6);
    repeat (2) @(negedge clk);
    check("R4 wake after dropouts", status, 3);
    count_state(2'd3, n);
    check("R6 latency fast", n, 100);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cycle(0, 0, 0, 0, 1);
    t_cycle(1, 1, 5, 0, 0);
    t_cycle(0, 1, 0, 1, 1);
    t_cycle(1, 1, 63, 1, 0);
    t_dropout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule